// File: doc/BRIEF.md
# Simultaneous-Sample Serial Output Sequencer

This block is the digital face of a six-channel converter whose channels are all sampled at the same instant. A rising edge on the convert input captures every channel's 12-bit sample from a parallel port in one go. It also fixes how many channels the coming frame will handle, taken from a 3-bit count code. The block then counts rising edges of a serial clock. Each enabled channel owns a 16-edge slot of the frame. At the end of its slot, the channel's captured sample moves into that channel's result word.

While a frame runs, a single data line sends out the result words. These words hold what the previous frame captured. Channel 0 goes first and each word is sent MSB first. Every slot contains two high-impedance positions, then twelve data bits, then two filler bits driven low. A separate enable output models the three-state driver.

All inputs are synchronous levels on the block's system clock, and the block finds their rising edges itself. Every output change is registered on the system clock edge that sees the serial clock rise.

Top module: `sss_seq`

## Requirements
- R1: The count code is latched on an accepted convert edge. Code n (0 to 4) enables channels 0..n. Codes 5, 6 and 7 enable all six channels. A frame is exactly 16 times the channel count serial clock rising edges long.
- R2: A convert rising edge arriving while a frame is running, before its final serial edge, is ignored. It changes neither the frame, the captured samples nor the latched count.
- R3: When the final serial edge of a frame has occurred, the frame ends. A serial edge after that, with no new convert edge, puts the data line into high impedance (enable low).
- R4: Within a slot, number the serial edges 1 to 16. After edges 1 and 2 the enable is low. After edges 3 to 14 the enable is high and the line carries data bits 11 down to 0. After edges 15 and 16 the enable is high and the line is driven 0.
- R5: Slots run in ascending channel order. The first data bit of a frame is bit 11 of channel 0's word.
- R6: The word sent for a channel is the sample captured by the previous accepted convert edge, provided that edge's frame enabled the channel.
- R7: A channel's word changes only at the end of that channel's slot. Channels outside a shorter frame keep their older words and send them again when later enabled.
- R8: After reset all result words are zero and the enable is low. It stays low, even on serial edges, until a frame's data positions are reached.
- R9: An accepted convert edge sets the enable low at that clock edge.
- R10: A convert edge in the same cycle as a frame's final serial edge is accepted. The last channel of the ending frame still takes its new word, and a new frame starts.
- R11: Samples are captured only at the accepted convert edge. Changes on the sample or count inputs afterwards have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck_i | input | 1 | Serial clock level, synchronous to clk |
| conv_i | input | 1 | Convert request level, synchronous to clk |
| sel_i | input | 3 | Channel-count code |
| smp_i | input | 72 | Six 12-bit samples, channel k at bits 12k+11..12k |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Data line driver enable (low = high impedance) |

## Verification
Two events can land in one clock: the final serial edge of a frame, which must still move the last channel's word into its result latch, and a new convert edge, which restarts the count and forces high impedance. The bench raises the convert input in the same cycle as the last serial clock rise of every other frame. It checks that the enable drops at once. The next frame then shows whether the last channel's word was refreshed and whether the following frame was counted from that edge. Convert edges injected one edge before the end of a frame test the other side of the same boundary.

// File: rtl/sss_pkg.sv
package sss_pkg;
    parameter int NCH    = 6;
    parameter int DW     = 12;
    parameter int LEAD_Z = 2;
    parameter int TRAIL_X = 2;
    parameter int SELW   = 3;

    localparam int SLOT = DW + LEAD_Z + TRAIL_X;
    localparam int CHW  = $clog2(NCH);
    localparam int RW   = $clog2(SLOT);
    localparam int CNTW = $clog2(NCH + 1);
    localparam int BW   = $clog2(DW);

    typedef logic [DW-1:0] word_t;

    function automatic logic [CNTW-1:0] chan_count(logic [SELW-1:0] code);
        if (int'(code) >= NCH) return CNTW'(NCH);
        return CNTW'(int'(code) + 1);
    endfunction
endpackage

// File: rtl/sss_edge_det.sv
module sss_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/sss_frame_ctl.sv
module sss_frame_ctl
    import sss_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck_rise_i,
    input  logic            conv_rise_i,
    input  logic [SELW-1:0] sel_i,
    output logic            accept_o,
    output logic            step_o,
    output logic            slot_end_o,
    output logic            idle_tick_o,
    output logic [CHW-1:0]  ch_o,
    output logic [RW-1:0]   pos_o
);
    localparam logic [RW-1:0] POS_LAST = RW'(SLOT - 1);

    typedef struct packed {
        logic            active;
        logic [CHW-1:0]  ch;
        logic [RW-1:0]   pos;
        logic [CNTW-1:0] nch;
    } ctl_t;

    ctl_t st_d, st_q;
    logic final_edge;

    always_comb begin
        step_o      = sck_rise_i & st_q.active;
        slot_end_o  = step_o & (st_q.pos == POS_LAST);
        final_edge  = slot_end_o & ((CNTW'(st_q.ch) + CNTW'(1)) == st_q.nch);
        accept_o    = conv_rise_i & (~st_q.active | final_edge);
        idle_tick_o = sck_rise_i & ~st_q.active;
        ch_o        = st_q.ch;
        pos_o       = st_q.pos;

        st_d = st_q;
        if (step_o) begin
            if (slot_end_o) begin
                st_d.pos = '0;
                st_d.ch  = st_q.ch + 1'b1;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
            if (final_edge) st_d.active = 1'b0;
        end
        if (accept_o) begin
            st_d.active = 1'b1;
            st_d.ch     = '0;
            st_d.pos    = '0;
            st_d.nch    = chan_count(sel_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= 1'b0;
            st_q.ch     <= '0;
            st_q.pos    <= '0;
            st_q.nch    <= CNTW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    // R1: the latched count stays within 1..NCH and the slot index below it
    assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.nch >= CNTW'(1)) && (st_q.nch <= CNTW'(NCH)));
    assert_slot_below_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (CNTW'(st_q.ch) < st_q.nch));
    // R2: a convert edge inside a frame with no serial edge leaves the frame untouched
    assert_lockout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_rise_i && st_q.active && !sck_rise_i)
        |=> (st_q.active && $stable(st_q.ch) && $stable(st_q.pos) && $stable(st_q.nch)));
    // R3: the final edge without a convert edge ends the frame
    assert_frame_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (final_edge && !conv_rise_i) |=> !st_q.active);
    // R10: a convert edge on the final edge restarts at slot 0
    assert_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (final_edge && conv_rise_i) |=> (st_q.active && st_q.ch == '0 && st_q.pos == '0));
endmodule

// File: rtl/sss_result_bank.sv
module sss_result_bank
    import sss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              slot_end_i,
    input  logic [CHW-1:0]    ch_i,
    input  logic [NCH*DW-1:0] smp_i,
    output logic [DW-1:0]     rd_word_o
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] held;
        logic [NCH-1:0][DW-1:0] outw;
    } bank_t;

    bank_t st_d, st_q;
    logic [NCH-1:0][DW-1:0] smp_w;

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign smp_w[g] = smp_i[g*DW +: DW];
    end

    always_comb begin
        st_d = st_q;
        if (accept_i) st_d.held = smp_w;
        for (int j = 0; j < NCH; j++) begin
            if (slot_end_i && ch_i == CHW'(j)) st_d.outw[j] = st_q.held[j];
        end
        rd_word_o = '0;
        for (int j = 0; j < NCH; j++) begin
            if (ch_i == CHW'(j)) rd_word_o = st_q.outw[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: captured samples move only on an accepted convert edge
    assert_capture_only_on_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> $stable(st_q.held));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R7: a word changes only at the end of its own slot
        assert_word_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(slot_end_i && ch_i == CHW'(g)) |=> $stable(st_q.outw[g]));
    end
endmodule

// File: rtl/sss_serializer.sv
module sss_serializer
    import sss_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic          step_i,
    input  logic          idle_tick_i,
    input  logic [RW-1:0] pos_i,
    input  logic [DW-1:0] rd_word_i,
    output logic          sdo_o,
    output logic          oe_o
);
    localparam int DATA_END = LEAD_Z + DW;

    typedef struct packed {
        logic sdo;
        logic oe;
    } ser_t;

    ser_t st_d, st_q;
    logic [BW-1:0] bidx;

    always_comb begin
        bidx = BW'(DATA_END - 1 - int'(pos_i));
        st_d = st_q;
        if (accept_i) begin
            st_d.oe  = 1'b0;
            st_d.sdo = 1'b0;
        end else if (step_i) begin
            if (int'(pos_i) < LEAD_Z) begin
                st_d.oe  = 1'b0;
                st_d.sdo = 1'b0;
            end else if (int'(pos_i) < DATA_END) begin
                st_d.oe  = 1'b1;
                st_d.sdo = rd_word_i[bidx];
            end else begin
                st_d.oe  = 1'b1;
                st_d.sdo = 1'b0;
            end
        end else if (idle_tick_i) begin
            st_d.oe  = 1'b0;
            st_d.sdo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_o = st_q.sdo;
    assign oe_o  = st_q.oe;

    // R9: accepted convert edge releases the line
    assert_accept_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> !oe_o);
    // R4: leading slot positions are high impedance
    assert_lead_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !accept_i && int'(pos_i) < LEAD_Z) |=> !oe_o);
    // R4: data and filler positions are driven
    assert_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !accept_i && int'(pos_i) >= LEAD_Z) |=> oe_o);
    // R4: filler positions drive zero
    assert_filler_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !accept_i && int'(pos_i) >= DATA_END) |=> !sdo_o);
    // R3: a serial edge outside any frame releases the line
    assert_idle_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_tick_i && !accept_i) |=> !oe_o);
endmodule

// File: rtl/sss_seq.sv
module sss_seq
    import sss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              conv_i,
    input  logic [SELW-1:0]   sel_i,
    input  logic [NCH*DW-1:0] smp_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    logic [1:0]     rises;
    logic           accept, step, slot_end, idle_tick;
    logic [CHW-1:0] ch;
    logic [RW-1:0]  pos;
    logic [DW-1:0]  rd_word;

    sss_edge_det #(.N(2)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({conv_i, sck_i}),
        .rise_o (rises)
    );

    sss_frame_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_rise_i  (rises[0]),
        .conv_rise_i (rises[1]),
        .sel_i       (sel_i),
        .accept_o    (accept),
        .step_o      (step),
        .slot_end_o  (slot_end),
        .idle_tick_o (idle_tick),
        .ch_o        (ch),
        .pos_o       (pos)
    );

    sss_result_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .slot_end_i (slot_end),
        .ch_i       (ch),
        .smp_i      (smp_i),
        .rd_word_o  (rd_word)
    );

    sss_serializer u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .step_i      (step),
        .idle_tick_i (idle_tick),
        .pos_i       (pos),
        .rd_word_i   (rd_word),
        .sdo_o       (sdo_o),
        .oe_o        (sdo_oe_o)
    );
endmodule

// File: tb/sss_seq_test.sv
module sss_seq_test;
    import sss_pkg::*;

    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic conv = 1'b0;
    logic [SELW-1:0] sel = '0;
    logic [NCH*DW-1:0] smp = '0;
    logic sdo, oe;

    sss_seq uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck),
        .conv_i   (conv),
        .sel_i    (sel),
        .smp_i    (smp),
        .sdo_o    (sdo),
        .sdo_oe_o (oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int misses = 0;
    logic [DW-1:0] expw [NCH];
    logic [DW-1:0] hold_e [NCH];
    int src [NCH];
    int hold_fid = 0;
    int n_e = 1;
    int cur_fid = 0;
    bit armed = 1'b0;

    function automatic logic [DW-1:0] pat(int f, int c);
        return DW'((f * 1237 + c * 419 + 77) % (1 << DW));
    endfunction

    function automatic int count_of(int s);
        return (s + 1 > NCH) ? NCH : s + 1;
    endfunction

    task automatic check(string tag, logic e_oe, logic e_sdo);
        vectors++;
        if (oe !== e_oe || (e_oe && sdo !== e_sdo)) begin
            misses++;
            $display("FAIL %s: oe/sdo = %b/%b, expected %b/%b", tag, oe, sdo, e_oe, e_sdo);
        end
    endtask

    task automatic load(int s, int f);
        sel = SELW'(s);
        for (int c = 0; c < NCH; c++) smp[c*DW +: DW] = pat(f, c);
    endtask

    task automatic capture(int s, int f);
        for (int c = 0; c < NCH; c++) hold_e[c] = pat(f, c);
        hold_fid = f;
        n_e = count_of(s);
        cur_fid = f;
    endtask

    task automatic scramble();
        smp = ~smp;
        sel = ~sel;
    endtask

    task automatic conv_pulse();
        @(negedge clk);
        conv = 1'b1;
        @(negedge clk);
        conv = 1'b0;
    endtask

    task automatic sck_edge(bit with_conv);
        @(negedge clk);
        sck = 1'b1;
        conv = with_conv;
        @(negedge clk);
        sck = 1'b0;
        conv = 1'b0;
    endtask

    task automatic start_frame(int s, int f);
        load(s, f);
        conv_pulse();
        capture(s, f);
        check("R9 accept releases line", 1'b0, 1'b0);
        scramble();
    endtask

    task automatic edge_expect(int m, string extra);
        int r, ch, b;
        string tag;
        r = m % SLOT;
        ch = m / SLOT;
        if (r < LEAD_Z) begin
            check({"R4 lead hiz", extra}, 1'b0, 1'b0);
        end else if (r < LEAD_Z + DW) begin
            b = DW - 1 - (r - LEAD_Z);
            if (src[ch] < 0) tag = "R8 reset word";
            else if (src[ch] == cur_fid - 1) tag = "R6/R11 previous frame word";
            else tag = "R7 stale word";
            if (ch == 0 && r == LEAD_Z) tag = "R5 first bit of ch0";
            check({tag, extra}, 1'b1, expw[ch][b]);
        end else begin
            check({"R4 filler", extra}, 1'b1, 1'b0);
        end
        if (r == SLOT - 1) begin
            expw[ch] = hold_e[ch];
            src[ch] = hold_fid;
        end
    endtask

    task automatic run_body(int lock_at, bit chain, int ns, int nf);
        int total;
        string extra;
        total = n_e * SLOT;
        extra = (lock_at >= 0) ? " (R2 lockout frame)" : "";
        for (int m = 0; m < total; m++) begin
            if (m == lock_at) begin
                load(7, cur_fid + 500);
                conv_pulse();
            end
            if (chain && m == total - 1) begin
                load(ns, nf);
                sck_edge(1'b1);
                check("R10 coincident convert accepted", 1'b0, 1'b0);
                expw[m / SLOT] = hold_e[m / SLOT];
                src[m / SLOT] = hold_fid;
                capture(ns, nf);
                scramble();
            end else begin
                sck_edge(1'b0);
                edge_expect(m, extra);
            end
        end
        if (!chain) begin
            sck_edge(1'b0);
            check("R1/R3 frame length, idle edge", 1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        misses++;
        $display("FAIL watchdog: run still going, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            expw[c] = '0;
            src[c] = -1;
        end
        repeat (3) @(negedge clk);
        check("R8 reset state", 1'b0, 1'b0);
        sck_edge(1'b0);
        check("R8 serial edge in reset", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sck_edge(1'b0);
        check("R8 serial edge before first frame", 1'b0, 1'b0);

        start_frame(5, 1);
        run_body(-1, 1'b0, 0, 0);

        for (int k = 0; k < 16; k++) begin
            int s, f, lock, ns;
            bit chain;
            s = (k * 5 + 3) % 8;
            f = k + 2;
            if (!armed) start_frame(s, f);
            lock = (k % 3 == 0) ? count_of(s) * SLOT - 1 : ((k % 3 == 1) ? 7 : -1);
            chain = (k % 2 == 1) && (k < 15);
            ns = ((k + 1) * 5 + 3) % 8;
            run_body(lock, chain, ns, f + 1);
            armed = chain;
        end

        start_frame(6, 18);
        run_body(-1, 1'b0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule